// File: doc/BRIEF.md
# Queue Doorbell Decoder

This block sits on the register write path of a queue-based storage controller. It watches every host write. It claims the writes that land in the doorbell window and updates one pointer per queue. Each submission queue gets a tail pointer and each completion queue gets a head pointer. The block supports a parameterised number of queue pairs. Submission-tail and completion-head doorbells alternate in the window with an 8-byte stride per queue id. Submission tails sit on the 8-byte boundary and completion heads sit 4 bytes above it.

An accepted submission-tail write arms a per-queue countdown. When the countdown expires, the block emits a one-cycle start strobe to the fetch engine. An accepted completion-head write does two things:

- If the completion queue was full just before the write, it arms the countdown of every present submission queue bound to that completion queue, so that fetching resumes.
- If the completion queue's tail still differs from the new head, it re-raises that queue's interrupt strobe.

Queue presence, sizes, submission-to-completion bindings and the completion-queue tails come from the surrounding queue engines.

Top module: `doorbell_decoder`

## Requirements
- R1: After reset all pointers read zero and every strobe is low.
- R2: A write whose address is below the window base (0x1000), or whose address bits [1:0] are not zero, changes no pointer and raises no strobe.
- R3: A write to address 0x1000 + 8·q with data whose low 16 bits are below that submission queue's size sets the submission tail of q to those bits one cycle later. Data bits 31:16 are ignored.
- R4: A write to address 0x1000 + 8·q + 4 with low 16 bits below that completion queue's size sets the completion head of q to those bits one cycle later.
- R5: A write is dropped when any of the following holds: its low 16 bits are greater than or equal to the target queue's size, the target queue is not present, or q is not less than the queue count.
- R6: An accepted submission tail write produces one single-cycle start pulse for that queue. The pulse comes D cycles after the write is accepted, where D is the delay input, or 1 when the delay input is 0.
- R7: A further accepted write to a queue whose countdown is still running restarts the countdown. Only one start pulse results, D cycles after the last write.
- R8: When a completion queue is full before an accepted head write, every present submission queue bound to it receives a start pulse D cycles later. "Full" means that the tail advanced by one modulo the size equals the head. When the queue is not full, no wake results.
- R9: An accepted completion head write pulses that queue's interrupt strobe for one cycle, in the cycle after the write, if and only if the queue's tail differs from the new head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | DATA_W | Write data; low 16 bits carry the pointer |
| sq_present | input | NQ | Submission queue exists, one bit per queue |
| cq_present | input | NQ | Completion queue exists, one bit per queue |
| sq_size | input | NQ·16 | Entry count of each submission queue |
| cq_size | input | NQ·16 | Entry count of each completion queue |
| cq_tail | input | NQ·16 | Current tail of each completion queue, from the posting engine |
| sq_bind | input | NQ·QID_W | Completion queue id each submission queue reports to |
| start_delay | input | DLY_W | Countdown length in cycles before a start pulse |
| sq_tail | output | NQ·16 | Submission tail pointers |
| cq_head | output | NQ·16 | Completion head pointers |
| sq_start | output | NQ | One-cycle fetch start strobes |
| cq_irq | output | NQ | One-cycle interrupt re-raise strobes |

## Verification
Some rules are checked by the assertions on every cycle:

- a pointer never moves without a write;
- writes below the base or with unaligned addresses leave every pointer still;
- an oversize value never reaches the pointer it targets;
- an interrupt strobe only follows a head write to that same queue, and only while the tail differs from the new head.

Other behaviours show only in the bench scenarios:

- the exact countdown length, including the zero-delay case;
- the restart of a running countdown;
- the wake fan-out to every bound submission queue when a full completion queue is freed, and its absence when the queue is not full.

// File: rtl/dbl_pkg.sv
package dbl_pkg;

   // pointer width is fixed by the doorbell format: low half of the data word
   localparam int DB_PTR_W = 16;

   typedef enum logic {
      DB_SQ_TAIL = 1'b0,
      DB_CQ_HEAD = 1'b1
   } db_kind_e;

   // advance a ring index by one, wrapping at the queue size
   function automatic logic [DB_PTR_W-1:0] ring_inc(input logic [DB_PTR_W-1:0] p,
                                                    input logic [DB_PTR_W-1:0] sz);
      logic [DB_PTR_W-1:0] n;
      n = p + DB_PTR_W'(1);
      return (n == sz) ? '0 : n;
   endfunction

endpackage

// File: rtl/dbl_addr_decode.sv
module dbl_addr_decode
   import dbl_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int BASE   = 'h1000,
   parameter int NQ     = 4,
   parameter int QID_W  = 2
) (
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic              hit,
   output db_kind_e          kind,
   output logic [QID_W-1:0]  qid
);
   localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);

   logic [ADDR_W-1:0] off;
   logic [ADDR_W-1:0] slot;
   logic              above, aligned, in_rng;
   logic              unused_low;

   always_comb begin
      off     = wr_addr - BASE_A;
      slot    = off >> 3;
      above   = (wr_addr >= BASE_A);
      aligned = (wr_addr[1:0] == 2'b00);
      in_rng  = (slot < ADDR_W'(NQ));
      hit     = wr_valid && above && aligned && in_rng;
      kind    = off[2] ? DB_CQ_HEAD : DB_SQ_TAIL;
      qid     = slot[QID_W-1:0];
   end

   assign unused_low = ^off[1:0];

endmodule

// File: rtl/dbl_sq_slot.sv
module dbl_sq_slot
   import dbl_pkg::*;
#(
   parameter int DLY_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sel,
   input  logic [DB_PTR_W-1:0] val,
   input  logic [DB_PTR_W-1:0] size,
   input  logic                wake,
   input  logic [DLY_W-1:0]    delay,
   output logic [DB_PTR_W-1:0] tail,
   output logic                start
);
   logic             accept, arm;
   logic [DLY_W-1:0] load, cnt;

   always_comb begin
      accept = sel && (val < size);
      arm    = accept || wake;
      load   = (delay == '0) ? DLY_W'(1) : delay;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tail  <= '0;
         cnt   <= '0;
         start <= 1'b0;
      end else begin
         if (accept) tail <= val;
         // a fresh arm wins over an expiring count: restart, no pulse
         start <= !arm && (cnt == DLY_W'(1));
         if (arm)
            cnt <= load;
         else if (cnt != '0)
            cnt <= cnt - DLY_W'(1);
      end
   end

endmodule

// File: rtl/dbl_cq_slot.sv
module dbl_cq_slot
   import dbl_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sel,
   input  logic [DB_PTR_W-1:0] val,
   input  logic [DB_PTR_W-1:0] size,
   input  logic [DB_PTR_W-1:0] tail_in,
   output logic [DB_PTR_W-1:0] head,
   output logic                wake,
   output logic                irq
);
   logic accept, was_full;

   always_comb begin
      accept   = sel && (val < size);
      was_full = (ring_inc(tail_in, size) == head);
      wake     = accept && was_full;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head <= '0;
         irq  <= 1'b0;
      end else begin
         if (accept) head <= val;
         irq <= accept && (tail_in != val);
      end
   end

endmodule

// File: rtl/doorbell_decoder.sv
module doorbell_decoder
   import dbl_pkg::*;
#(
   parameter int NQ     = 4,
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int BASE   = 'h1000,
   parameter int DLY_W  = 8,
   localparam int QID_W = (NQ > 1) ? $clog2(NQ) : 1,
   localparam int PW    = DB_PTR_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_valid,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic [NQ-1:0]       sq_present,
   input  logic [NQ-1:0]       cq_present,
   input  logic [NQ*PW-1:0]    sq_size,
   input  logic [NQ*PW-1:0]    cq_size,
   input  logic [NQ*PW-1:0]    cq_tail,
   input  logic [NQ*QID_W-1:0] sq_bind,
   input  logic [DLY_W-1:0]    start_delay,
   output logic [NQ*PW-1:0]    sq_tail,
   output logic [NQ*PW-1:0]    cq_head,
   output logic [NQ-1:0]       sq_start,
   output logic [NQ-1:0]       cq_irq
);
   // register window: next power of two above the last doorbell plus the admin pair
   localparam int WIN_RAW = BASE + 4 + 2 * (NQ + 1) * 4;
   localparam int WIN     = 1 << $clog2(WIN_RAW + 1);

   if (NQ < 1) begin : g_bad_nq
      $error("doorbell_decoder: NQ must be at least 1");
   end
   if (DATA_W < PW) begin : g_bad_data
      $error("doorbell_decoder: DATA_W narrower than pointer");
   end
   if (ADDR_W < 31 && WIN > (1 << ADDR_W)) begin : g_bad_addr
      $error("doorbell_decoder: ADDR_W cannot reach the doorbell window");
   end
   if (DLY_W < 1) begin : g_bad_dly
      $error("doorbell_decoder: DLY_W must be at least 1");
   end

   logic             hit;
   db_kind_e         kind;
   logic [QID_W-1:0] qid;
   logic [PW-1:0]    val;
   logic [NQ-1:0]    cq_wake;

   assign val = wr_data[PW-1:0];

   if (DATA_W > PW) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^wr_data[DATA_W-1:PW];
   end

   dbl_addr_decode #(
      .ADDR_W(ADDR_W), .BASE(BASE), .NQ(NQ), .QID_W(QID_W)
   ) u_dec (
      .wr_valid(wr_valid),
      .wr_addr (wr_addr),
      .hit     (hit),
      .kind    (kind),
      .qid     (qid)
   );

   for (genvar i = 0; i < NQ; i++) begin : g_cq
      logic sel;
      assign sel = hit && (kind == DB_CQ_HEAD) && (qid == QID_W'(i)) && cq_present[i];

      dbl_cq_slot u_slot (
         .clk    (clk),
         .rst_n  (rst_n),
         .sel    (sel),
         .val    (val),
         .size   (cq_size[i*PW +: PW]),
         .tail_in(cq_tail[i*PW +: PW]),
         .head   (cq_head[i*PW +: PW]),
         .wake   (cq_wake[i]),
         .irq    (cq_irq[i])
      );
   end

   for (genvar i = 0; i < NQ; i++) begin : g_sq
      logic sel, wake;
      assign sel = hit && (kind == DB_SQ_TAIL) && (qid == QID_W'(i)) && sq_present[i];

      always_comb begin
         wake = 1'b0;
         for (int j = 0; j < NQ; j++)
            if (sq_bind[i*QID_W +: QID_W] == QID_W'(j) && cq_wake[j])
               wake = sq_present[i];
      end

      dbl_sq_slot #(.DLY_W(DLY_W)) u_slot (
         .clk  (clk),
         .rst_n(rst_n),
         .sel  (sel),
         .val  (val),
         .size (sq_size[i*PW +: PW]),
         .wake (wake),
         .delay(start_delay),
         .tail (sq_tail[i*PW +: PW]),
         .start(sq_start[i])
      );
   end

endmodule

// File: rtl/dbl_chk.sv
module dbl_chk #(
   parameter int NQ     = 4,
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int BASE   = 'h1000,
   parameter int DLY_W  = 8,
   localparam int QID_W = (NQ > 1) ? $clog2(NQ) : 1,
   localparam int PW    = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_valid,
   input logic [ADDR_W-1:0]   wr_addr,
   input logic [DATA_W-1:0]   wr_data,
   input logic [NQ-1:0]       sq_present,
   input logic [NQ-1:0]       cq_present,
   input logic [NQ*PW-1:0]    sq_size,
   input logic [NQ*PW-1:0]    cq_size,
   input logic [NQ*PW-1:0]    cq_tail,
   input logic [NQ*QID_W-1:0] sq_bind,
   input logic [DLY_W-1:0]    start_delay,
   input logic [NQ*PW-1:0]    sq_tail,
   input logic [NQ*PW-1:0]    cq_head,
   input logic [NQ-1:0]       sq_start,
   input logic [NQ-1:0]       cq_irq
);
   // R2
   idle_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_valid |=> ($stable(sq_tail) && $stable(cq_head)));

   // R2
   below_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_addr < ADDR_W'(BASE)) |=> ($stable(sq_tail) && $stable(cq_head)));

   // R2
   unaligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_addr[1:0] != 2'b00) |=> ($stable(sq_tail) && $stable(cq_head)));

   for (genvar i = 0; i < NQ; i++) begin : g_q
      // R5
      sq_oversize_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_valid && wr_addr == ADDR_W'(BASE + 8*i) && wr_data[PW-1:0] >= sq_size[i*PW +: PW])
         |=> $stable(sq_tail[i*PW +: PW]));

      // R5
      cq_oversize_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_valid && wr_addr == ADDR_W'(BASE + 8*i + 4) && wr_data[PW-1:0] >= cq_size[i*PW +: PW])
         |=> ($stable(cq_head[i*PW +: PW]) && !cq_irq[i]));

      // R9
      irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cq_irq[i] |-> $past(wr_valid && wr_addr == ADDR_W'(BASE + 8*i + 4)));

      // R9
      irq_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cq_irq[i] |-> ($past(cq_tail[i*PW +: PW]) != cq_head[i*PW +: PW]));
   end

   logic unused_chk;
   assign unused_chk = ^{sq_present, cq_present, sq_bind, start_delay, sq_start, wr_data[DATA_W-1:PW]};

endmodule

bind doorbell_decoder dbl_chk #(
   .NQ(NQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE(BASE), .DLY_W(DLY_W)
) u_chk (.*);

// File: tb/doorbell_decoder_tb.sv
`timescale 1ns/1ps
module doorbell_decoder_tb;
   localparam int NQ = 4;
   localparam int QW = 2;
   localparam int BASE = 'h1000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_valid = 1'b0;
   logic [15:0] wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [NQ-1:0] sq_present, cq_present;
   logic [15:0] sqs [NQ];
   logic [15:0] cqs [NQ];
   logic [15:0] cqt [NQ];
   logic [NQ*16-1:0] sq_size, cq_size, cq_tail;
   logic [NQ*QW-1:0] sq_bind;
   logic [7:0] start_delay;
   logic [NQ*16-1:0] sq_tail, cq_head;
   logic [NQ-1:0] sq_start, cq_irq;

   assign sq_size = {sqs[3], sqs[2], sqs[1], sqs[0]};
   assign cq_size = {cqs[3], cqs[2], cqs[1], cqs[0]};
   assign cq_tail = {cqt[3], cqt[2], cqt[1], cqt[0]};

   always #2 clk = ~clk;

   doorbell_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
      .sq_present(sq_present), .cq_present(cq_present), .sq_size(sq_size), .cq_size(cq_size),
      .cq_tail(cq_tail), .sq_bind(sq_bind), .start_delay(start_delay),
      .sq_tail(sq_tail), .cq_head(cq_head), .sq_start(sq_start), .cq_irq(cq_irq)
   );

   int n_run = 0;
   int n_fail = 0;
   int pcyc = 0;
   bit fin = 1'b0;

   typedef struct {
      int    cyc;
      bit    irq;
      int    idx;
      string req;
   } ev_t;
   ev_t exp_q[$];

   logic [15:0] m_sq [NQ];
   logic [15:0] m_cq [NQ];

   always @(posedge clk) pcyc = pcyc + 1;

   // monitor: compares strobes against the scoreboard at each falling edge
   task automatic match(input bit irq, input int i, input bit seen);
      int f;
      f = -1;
      foreach (exp_q[k]) if (f < 0 && exp_q[k].cyc == pcyc && exp_q[k].irq == irq && exp_q[k].idx == i) f = k;
      if (seen || f >= 0) begin
         n_run++;
         if (seen && f < 0) begin
            n_fail++;
            $display("FAIL %s strobe %0d cycle %0d: actual 1 expected 0", irq ? "R9 irq" : "R6 start", i, pcyc);
         end else if (!seen) begin
            n_fail++;
            $display("FAIL %s strobe %0d cycle %0d: actual 0 expected 1", exp_q[f].req, i, pcyc);
         end
         if (f >= 0) exp_q.delete(f);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !fin) begin
         for (int i = 0; i < NQ; i++) begin
            match(1'b0, i, sq_start[i]);
            match(1'b1, i, cq_irq[i]);
         end
      end
   end

   function automatic int dly();
      return (start_delay == 0) ? 1 : int'(start_delay);
   endfunction

   task automatic push_start(input int q, input string req);
      ev_t e;
      for (int k = exp_q.size() - 1; k >= 0; k--)
         if (!exp_q[k].irq && exp_q[k].idx == q) exp_q.delete(k);
      e.cyc = pcyc + 1 + dly(); e.irq = 1'b0; e.idx = q; e.req = req;
      exp_q.push_back(e);
   endtask

   task automatic wr(input logic [15:0] a, input logic [31:0] d);
      wr_valid = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_valid = 1'b0; wr_addr = '0; wr_data = '0;
   endtask

   task automatic check_ptrs(input string req);
      for (int i = 0; i < NQ; i++) begin
         n_run++;
         if (sq_tail[i*16 +: 16] !== m_sq[i]) begin
            n_fail++;
            $display("FAIL %s sq_tail[%0d]: actual %0h expected %0h", req, i, sq_tail[i*16 +: 16], m_sq[i]);
         end
         n_run++;
         if (cq_head[i*16 +: 16] !== m_cq[i]) begin
            n_fail++;
            $display("FAIL %s cq_head[%0d]: actual %0h expected %0h", req, i, cq_head[i*16 +: 16], m_cq[i]);
         end
      end
   endtask

   // driver: submission tail doorbell
   task automatic sq_db(input int q, input logic [31:0] d, input bit ok, input string req);
      if (ok) begin
         push_start(q, req);
         m_sq[q] = d[15:0];
      end
      wr(16'(BASE + 8*q), d);
      check_ptrs(req);
   endtask

   // driver: completion head doorbell; wake lists the submission queues expected to start
   task automatic cq_db(input int q, input logic [31:0] d, input bit ok, input bit irq,
                        input logic [NQ-1:0] wake, input string req);
      ev_t e;
      if (ok) m_cq[q] = d[15:0];
      if (irq) begin
         e.cyc = pcyc + 1; e.irq = 1'b1; e.idx = q; e.req = req;
         exp_q.push_back(e);
      end
      for (int i = 0; i < NQ; i++) if (wake[i]) push_start(i, req);
      wr(16'(BASE + 8*q + 4), d);
      check_ptrs(req);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!fin) begin
         fin = 1'b1;
         n_run++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         summary();
         $finish;
      end
   end

   initial begin
      sq_present = 4'b1111;
      cq_present = 4'b0111;
      for (int i = 0; i < NQ; i++) begin
         sqs[i] = 16; cqs[i] = 16; cqt[i] = 0; m_sq[i] = 0; m_cq[i] = 0;
      end
      cqs[1] = 8; cqt[1] = 4;
      cqs[2] = 4; cqt[2] = 3;
      sq_bind = {2'd2, 2'd0, 2'd1, 2'd2};
      start_delay = 8'd3;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      check_ptrs("R1");
      n_run++;
      if (sq_start !== '0 || cq_irq !== '0) begin
         n_fail++;
         $display("FAIL R1 strobes: actual %b/%b expected 0/0", sq_start, cq_irq);
      end

      // R3 R6 basic submission tail, start after 3 cycles
      sq_db(0, 32'h0000_0005, 1'b1, "R3");
      idle(6);
      // R3 upper data bits ignored
      sq_db(1, 32'hABCD_0007, 1'b1, "R3");
      idle(6);

      // R4 R9 R8 head update on non-full queue: irq (tail 4 != 2), no wake
      cq_db(1, 32'h0000_0002, 1'b1, 1'b1, 4'b0000, "R4");
      idle(2);
      // R9 head catches up with tail: no irq
      cq_db(1, 32'h0000_0004, 1'b1, 1'b0, 4'b0000, "R9");
      idle(2);

      // R2 unaligned and below-base writes ignored
      wr(16'(BASE + 1), 32'h0000_0001);
      check_ptrs("R2");
      wr(16'(BASE + 8 + 6), 32'h0000_0001);
      check_ptrs("R2");
      wr(16'h0FF8, 32'h0000_0002);
      check_ptrs("R2");
      wr(16'h0000, 32'h0000_0003);
      check_ptrs("R2");
      idle(5);

      // R5 drops: oversize, absent queue, queue id out of range
      sq_db(0, 32'h0000_0010, 1'b0, "R5");
      cq_db(1, 32'h0000_0008, 1'b0, 1'b0, 4'b0000, "R5");
      cq_db(3, 32'h0000_0001, 1'b0, 1'b0, 4'b0000, "R5");
      wr(16'(BASE + 8*NQ), 32'h0000_0001);
      check_ptrs("R5");
      wr(16'(BASE + 8*NQ + 4), 32'h0000_0001);
      check_ptrs("R5");
      idle(6);

      // R7 back-to-back writes restart the countdown: single pulse
      sq_db(2, 32'h0000_0001, 1'b1, "R7");
      sq_db(2, 32'h0000_0002, 1'b1, "R7");
      idle(2);
      sq_db(2, 32'h0000_0003, 1'b1, "R7");
      idle(6);

      // R8 full completion queue: wake SQ0 and SQ3 (both bound to CQ2), irq (3 != 1)
      cq_db(2, 32'h0000_0001, 1'b1, 1'b1, 4'b1001, "R8");
      idle(6);
      // R8 no longer full: irq only, no wake
      cq_db(2, 32'h0000_0002, 1'b1, 1'b1, 4'b0000, "R8");
      idle(6);

      // R6 zero delay behaves as one cycle
      start_delay = 8'd0;
      sq_db(3, 32'h0000_000F, 1'b1, "R6");
      idle(4);
      // R6 longer delay
      start_delay = 8'd9;
      sq_db(1, 32'h0000_0001, 1'b1, "R6");
      idle(14);

      n_run++;
      if (exp_q.size() != 0) begin
         n_fail++;
         $display("FAIL R6 pending strobes: actual %0d expected 0", exp_q.size());
      end
      fin = 1'b1;
      summary();
      $finish;
   end

endmodule